// File: doc/BRIEF.md
# SPI Program-RAM Loader Sequencer

This block is an SPI master that brings up a slave device whose embedded controller runs from a program RAM that can be written over SPI. After a `start` pulse it drives a fixed, ordered series of frames. The first holds the slave's controller in reset. The next reads a temperature register to prove the link works. If the `otp_en` strap is high, three frames burn a long-jump vector into the slave's one-time-programmable memory so that the slave boots from RAM. Then one write frame goes out per image byte, with a running RAM address. The last frame releases the controller.

Image bytes come from the host through a request/valid handshake, one byte per RAM frame. The image length and the strap are captured at `start`. A link readback of all-zeros or all-ones means the slave is absent or stuck. In that case the block flags an error and jumps straight to the release frame. `done` pulses once the release frame and its trailing chip-select gap have finished.

Top module: `ram_image_loader`

## Requirements
- R1: The first frame after `start` is the three bytes 0x16, 0x2F, 0x01.
- R2: The second frame is 0x19, 0xB4, 0x00. The byte clocked in on MISO during its third byte is taken as the link readback.
- R3: A readback of 0x00 or 0xFF sets `error`. The only frame that follows is the release frame, with no OTP frame, no RAM frame and no byte request.
- R4: With `otp_en` high at `start`, three four-byte OTP frames follow the link check in this order: 0x07 0x00 0x00 0x02, then 0x07 0x00 0x01 0x20, then 0x07 0x00 0x02 0x00. With `otp_en` low, no frame starting with 0x07 is sent.
- R5: Each image byte is sent as the frame 0x1F, address high, address low, data. The first address is parameter RAM_BASE and each later frame adds one, with a carry into the high byte. The number of RAM frames equals `img_len` as captured at `start`, so a length of 0 sends none.
- R6: A byte is taken in the cycle where `byte_req` and `byte_vld` are both high. `byte_req` is high only while no frame is in progress. While `byte_req` is low, `byte_vld` has no effect.
- R7: The release frame 0x16, 0x2F, 0x00 is the last frame. `done` is high for exactly one cycle after it. `error` stays valid until the next `start`, which clears it.
- R8: SPI mode 0, MSB first. SCLK is low whenever CS_n is high. Within a frame, SCLK has a period of CLK_DIV system clocks, and MOSI does not change while SCLK is high.
- R9: CS_n stays low for a whole frame and stays high for at least two SCLK periods between frames.
- R10: `start`, `otp_en` and `img_len` are ignored while a load is running.
- R11: After reset, `spi_cs_n` = 1, `spi_sclk` = 0, and `done`, `error` and `byte_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (ignored while busy) |
| otp_en | input | 1 | Strap: burn the jump vector into OTP |
| img_len | input | LEN_W | Number of image bytes, captured at start |
| byte_req | output | 1 | Block is waiting for the next image byte |
| byte_vld | input | 1 | `byte_data` holds a valid image byte |
| byte_data | input | 8 | Image byte |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| error | output | 1 | Link check failed on the last load |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to the slave |
| spi_miso | input | 1 | SPI data from the slave |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
A wrong sequencer state shows on the bus within a single frame. It appears as a missing, repeated or reordered frame, as an OTP or RAM frame after a failed link check, or as a RAM address that skips or repeats, and it surfaces at the latest by the `done` of the same load. A wrong shift-engine state shows within one SCLK period as a bad bit count, a clock edge while CS_n is high, or a chip-select gap that is too short. The bench decodes every frame from the pins and compares the whole frame list with one built arithmetically from the strap, the length, the readback and RAM_BASE. The sweep covers a RAM_BASE near a page boundary, so that carry into the high address byte is exercised.

// File: rtl/imgload_pkg.sv
// Shared constants, state type and frame type for the SPI program-RAM loader.
// Assumes frames are at most four bytes, stored MSB-first and left-aligned.
package imgload_pkg;

    localparam logic [7:0] OP_CTRL    = 8'h16;
    localparam logic [7:0] REG_CTRL   = 8'h2F;
    localparam logic [7:0] OP_RD_TEMP = 8'h19;
    localparam logic [7:0] REG_TEMP   = 8'hB4;
    localparam logic [7:0] OP_OTP_WR  = 8'h07;
    localparam logic [7:0] OP_RAM_WR  = 8'h1F;
    localparam logic [7:0] JMP_OPCODE = 8'h02;
    localparam logic [15:0] JMP_TARGET = 16'h2000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LINK,
        ST_OTP,
        ST_FETCH,
        ST_RAM,
        ST_FREE
    } seq_state_t;

    typedef struct packed {
        logic [31:0] bytes;  // first byte on the wire in [31:24]
        logic        four;   // 1: four-byte frame, 0: three-byte frame
    } frame_t;

    // Byte k of the jump vector burned into OTP.
    function automatic logic [7:0] jump_byte(input logic [1:0] k);
        case (k)
            2'd0:    jump_byte = JMP_OPCODE;
            2'd1:    jump_byte = JMP_TARGET[15:8];
            default: jump_byte = JMP_TARGET[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
// SPI mode-0 shift engine that sends one three- or four-byte frame, MSB first.
// SCLK runs at clk/CLK_DIV (CLK_DIV even, at least 4). CS_n is held high for
// GAP_SCLKS SCLK periods after each frame before `fin` pulses.
// The last received byte stays on rx_byte until the next frame starts.
module spi_frame_shifter
    import imgload_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int GAP_SCLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  frame_t     frame,
    output logic       busy,
    output logic       fin,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       cs_n
);

    localparam int HALF    = CLK_DIV / 2;
    localparam int GAP_CYC = GAP_SCLKS * CLK_DIV;
    localparam int CW      = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);

    typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_t;

    sh_state_t     sh_q;
    logic [31:0]   tx_q;
    logic [5:0]    bits_q;
    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          cs_q;
    logic [7:0]    rx_q;
    logic          fin_q;

    // Frame timing: half-period counter, bit shifting and post-frame gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= SH_IDLE;
            tx_q   <= '0;
            bits_q <= '0;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            rx_q   <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (sh_q)
                SH_IDLE: begin
                    if (go) begin
                        tx_q   <= frame.bytes;
                        bits_q <= frame.four ? 6'd32 : 6'd24;
                        cs_q   <= 1'b0;
                        cnt_q  <= '0;
                        sh_q   <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rx_q   <= {rx_q[6:0], miso};
                        end else begin
                            sclk_q <= 1'b0;
                            tx_q   <= {tx_q[30:0], 1'b0};
                            bits_q <= bits_q - 6'd1;
                            if (bits_q == 6'd1) begin
                                cs_q <= 1'b1;
                                sh_q <= SH_GAP;
                            end
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SH_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        cnt_q <= '0;
                        fin_q <= 1'b1;
                        sh_q  <= SH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: sh_q <= SH_IDLE;
            endcase
        end
    end

    assign busy    = (sh_q != SH_IDLE);
    assign fin     = fin_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign cs_n    = cs_q;
    assign mosi    = cs_q ? 1'b0 : tx_q[31];

    // Cycles CS_n has been high, saturating; used only by the gap check.
    logic [CW:0] gap_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_seen_q <= (CW+1)'(GAP_CYC);
        else if (!cs_q)
            gap_seen_q <= '0;
        else if (gap_seen_q < (CW+1)'(GAP_CYC))
            gap_seen_q <= gap_seen_q + 1'b1;
    end

    a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r8_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(mosi));

    a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap_seen_q >= (CW+1)'(GAP_CYC)));

endmodule

// File: rtl/imgload_seq.sv
// Load sequencer: picks the next frame (hold, link check, optional OTP jump
// vector, one RAM write per image byte, release) and fetches image bytes
// through the request/valid handshake. It assumes the shifter returns one
// `frame_fin` for each accepted `frame_go`.
module imgload_seq
    import imgload_pkg::*;
#(
    parameter int          LEN_W    = 16,
    parameter logic [15:0] RAM_BASE = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             otp_en,
    input  logic [LEN_W-1:0] img_len,
    output logic             byte_req,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic             frame_go,
    output frame_t           frame,
    input  logic             frame_fin,
    input  logic             frame_busy,
    input  logic [7:0]       rx_byte,
    output logic             done,
    output logic             error
);

    seq_state_t       state_q;
    logic             issued_q;
    logic             otp_q;
    logic [LEN_W-1:0] left_q;
    logic [15:0]      addr_q;
    logic [1:0]       otp_idx_q;
    logic [7:0]       data_q;
    logic             done_q;
    logic             err_q;
    logic             frame_state;

    // States that own a frame on the wire.
    always_comb begin
        case (state_q)
            ST_HOLD, ST_LINK, ST_OTP, ST_RAM, ST_FREE: frame_state = 1'b1;
            default:                                   frame_state = 1'b0;
        endcase
    end

    assign frame_go = frame_state && !issued_q && !frame_busy;
    assign byte_req = (state_q == ST_FETCH) && (left_q != '0);
    assign done     = done_q;
    assign error    = err_q;

    // Build the bytes of the frame that belongs to the current state.
    always_comb begin
        frame.bytes = '0;
        frame.four  = 1'b0;
        case (state_q)
            ST_HOLD: frame.bytes = {OP_CTRL, REG_CTRL, 8'h01, 8'h00};
            ST_LINK: frame.bytes = {OP_RD_TEMP, REG_TEMP, 8'h00, 8'h00};
            ST_OTP: begin
                frame.bytes = {OP_OTP_WR, 8'h00, {6'b0, otp_idx_q}, jump_byte(otp_idx_q)};
                frame.four  = 1'b1;
            end
            ST_RAM: begin
                frame.bytes = {OP_RAM_WR, addr_q, data_q};
                frame.four  = 1'b1;
            end
            ST_FREE: frame.bytes = {OP_CTRL, REG_CTRL, 8'h00, 8'h00};
            default: frame.bytes = '0;
        endcase
    end

    // Sequence progression, configuration capture, address and count tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            issued_q  <= 1'b0;
            otp_q     <= 1'b0;
            left_q    <= '0;
            addr_q    <= '0;
            otp_idx_q <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_go)
                issued_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        otp_q     <= otp_en;
                        left_q    <= img_len;
                        addr_q    <= RAM_BASE;
                        otp_idx_q <= '0;
                        err_q     <= 1'b0;
                        issued_q  <= 1'b0;
                        state_q   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (frame_fin) begin
                        issued_q <= 1'b0;
                        state_q  <= ST_LINK;
                    end
                end
                ST_LINK: begin
                    if (frame_fin) begin
                        issued_q <= 1'b0;
                        if (rx_byte == 8'h00 || rx_byte == 8'hFF) begin
                            err_q   <= 1'b1;
                            state_q <= ST_FREE;
                        end else if (otp_q) begin
                            state_q <= ST_OTP;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_OTP: begin
                    if (frame_fin) begin
                        issued_q <= 1'b0;
                        if (otp_idx_q == 2'd2)
                            state_q <= ST_FETCH;
                        else
                            otp_idx_q <= otp_idx_q + 2'd1;
                    end
                end
                ST_FETCH: begin
                    if (left_q == '0) begin
                        state_q <= ST_FREE;
                    end else if (byte_vld) begin
                        data_q  <= byte_data;
                        state_q <= ST_RAM;
                    end
                end
                ST_RAM: begin
                    if (frame_fin) begin
                        issued_q <= 1'b0;
                        addr_q   <= addr_q + 16'd1;
                        left_q   <= left_q - LEN_W'(1);
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FREE: begin
                    if (frame_fin) begin
                        issued_q <= 1'b0;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r3_no_write_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (state_q != ST_OTP && state_q != ST_RAM && state_q != ST_FETCH));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q) == ST_FREE));

    a_r6_req_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> !frame_busy);

    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(otp_q));

endmodule

// File: rtl/ram_image_loader.sv
// Top of the SPI program-RAM loader: the sequencer feeding the shift engine.
// Assumes CLK_DIV is even and at least 4, and img_len is stable at start.
module ram_image_loader
    import imgload_pkg::*;
#(
    parameter int          CLK_DIV   = 4,
    parameter int          GAP_SCLKS = 2,
    parameter int          LEN_W     = 16,
    parameter logic [15:0] RAM_BASE  = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             otp_en,
    input  logic [LEN_W-1:0] img_len,
    output logic             byte_req,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    output logic             done,
    output logic             error,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);

    logic       go;
    frame_t     frm;
    logic       fin;
    logic       busy;
    logic [7:0] rx;

    imgload_seq #(
        .LEN_W   (LEN_W),
        .RAM_BASE(RAM_BASE)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .otp_en    (otp_en),
        .img_len   (img_len),
        .byte_req  (byte_req),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .frame_go  (go),
        .frame     (frm),
        .frame_fin (fin),
        .frame_busy(busy),
        .rx_byte   (rx),
        .done      (done),
        .error     (error)
    );

    spi_frame_shifter #(
        .CLK_DIV  (CLK_DIV),
        .GAP_SCLKS(GAP_SCLKS)
    ) shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .frame  (frm),
        .busy   (busy),
        .fin    (fin),
        .rx_byte(rx),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .miso   (spi_miso),
        .cs_n   (spi_cs_n)
    );

endmodule

// File: tb/ram_image_loader_tb_top.sv
// Bench: a slave model decodes frames from the pins and drives the link
// readback; a host model supplies image bytes with stalls and stray valids.
// The whole frame list of each load is compared with an arithmetic expectation.
module ram_image_loader_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          DIV        = 4;
    localparam int          LW         = 8;
    localparam logic [15:0] BASE       = 16'h20FE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          otp_en = 1'b0;
    logic [LW-1:0] img_len = '0;
    logic          byte_req;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = 8'h00;
    logic          done;
    logic          error;
    logic          spi_sclk;
    logic          spi_mosi;
    logic          spi_miso;
    logic          spi_cs_n;

    ram_image_loader #(
        .CLK_DIV  (DIV),
        .GAP_SCLKS(2),
        .LEN_W    (LW),
        .RAM_BASE (BASE)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .otp_en   (otp_en),
        .img_len  (img_len),
        .byte_req (byte_req),
        .byte_vld (byte_vld),
        .byte_data(byte_data),
        .done     (done),
        .error    (error),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .spi_cs_n (spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [7:0] temp_val = 8'h5A;
    int         nbits = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] fb [0:3];
    logic [7:0] rec_b [0:31][0:3];
    int         rec_n [0:31];
    int         nfr = 0;
    int         sclk_bad = 0;
    int         idle_edge = 0;
    int         min_gap = 1000000;
    time        t_rise = 0;
    bit         have_rise = 1'b0;
    time        t_edge = 0;

    assign spi_miso = (!spi_cs_n && fb[0] == 8'h19 && nbits >= 16 && nbits < 24)
                      ? temp_val[23 - nbits] : 1'b0;

    always @(negedge spi_cs_n) begin
        nbits = 0;
        fb[0] = 8'h00;
        if (spi_sclk) idle_edge++;
        if (have_rise && int'(($time - t_rise) / CLK_PERIOD) < min_gap)
            min_gap = int'(($time - t_rise) / CLK_PERIOD);
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n) begin
            idle_edge++;
        end else begin
            if (nbits > 0 && ($time - t_edge) != DIV * CLK_PERIOD) sclk_bad++;
            t_edge = $time;
            cur = {cur[6:0], spi_mosi};
            nbits++;
            if (nbits % 8 == 0 && nbits <= 32) fb[nbits/8 - 1] = cur;
        end
    end

    always @(posedge spi_cs_n) begin
        if (nfr < 32) begin
            rec_n[nfr] = (nbits % 8 == 0) ? nbits / 8 : 99;
            for (int i = 0; i < 4; i++) rec_b[nfr][i] = fb[i];
        end
        nfr++;
        t_rise = $time;
        have_rise = 1'b1;
    end

    // ---------------- host byte source ----------------
    int  idx = 0;
    int  stall = 0;
    bit  offered = 1'b0;
    bit  noise = 1'b0;
    int  done_cnt = 0;
    int  done_long = 0;
    bit  done_prev = 1'b0;

    function automatic logic [7:0] img_byte(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    always @(negedge clk) begin
        noise = ~noise;
        if (offered && !byte_req) begin
            offered = 1'b0;
            idx++;
            stall = 0;
        end
        if (byte_req && !offered) begin
            if (stall >= idx % 3) begin
                byte_vld  = 1'b1;
                byte_data = img_byte(idx);
                offered   = 1'b1;
            end else begin
                stall++;
                byte_vld = 1'b0;
            end
        end else if (!offered) begin
            byte_vld  = noise;  // R6: stray valid while not requested
            byte_data = 8'hEE;
        end
        if (done) done_cnt++;
        if (done && done_prev) done_long++;
        done_prev = done;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- one load ----------------
    logic [7:0] exp_b [0:31][0:3];
    int         exp_n [0:31];
    string      exp_t [0:31];

    task automatic add_exp(inout int n, input int len, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input string tag);
        exp_n[n] = len;
        exp_b[n][0] = b0; exp_b[n][1] = b1; exp_b[n][2] = b2; exp_b[n][3] = b3;
        exp_t[n] = tag;
        n++;
    endtask

    task automatic run(input bit otp, input int len, input logic [7:0] tval, input bit disturb);
        int  n = 0;
        bit  err_exp;
        int  w = 0;
        logic [15:0] a;
        nfr = 0; sclk_bad = 0; idle_edge = 0; min_gap = 1000000; have_rise = 1'b0;
        idx = 0; done_cnt = 0; done_long = 0;
        temp_val = tval;
        @(negedge clk);
        img_len = LW'(len);
        otp_en  = otp;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(error == 1'b0, "R7 error cleared by start", int'(error), 0);
        if (disturb) begin
            repeat (200) @(negedge clk);
            start   = 1'b1;
            img_len = LW'(len + 3);
            otp_en  = ~otp;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        repeat (20) @(negedge clk);
        chk(done_cnt == 1 && done_long == 0, "R7 done single pulse", done_cnt, 1);

        // expected frame list
        err_exp = (tval == 8'h00 || tval == 8'hFF);
        add_exp(n, 3, 8'h16, 8'h2F, 8'h01, 8'h00, "R1 hold frame");
        add_exp(n, 3, 8'h19, 8'hB4, 8'h00, 8'h00, "R2 link frame");
        if (!err_exp) begin
            if (otp) begin
                add_exp(n, 4, 8'h07, 8'h00, 8'h00, 8'h02, "R4 otp frame 0");
                add_exp(n, 4, 8'h07, 8'h00, 8'h01, 8'h20, "R4 otp frame 1");
                add_exp(n, 4, 8'h07, 8'h00, 8'h02, 8'h00, "R4 otp frame 2");
            end
            for (int k = 0; k < len; k++) begin
                a = BASE + 16'(k);
                add_exp(n, 4, 8'h1F, a[15:8], a[7:0], img_byte(k), "R5 ram frame");
            end
        end
        add_exp(n, 3, 8'h16, 8'h2F, 8'h00, 8'h00, "R7 release frame");

        chk(nfr == n, disturb ? "R10 frame count with busy start" : "R3 R4 R5 frame count", nfr, n);
        for (int f = 0; f < n && f < nfr && f < 32; f++) begin
            bit ok = (rec_n[f] == exp_n[f]);
            for (int i = 0; i < exp_n[f]; i++) if (rec_b[f][i] !== exp_b[f][i]) ok = 1'b0;
            chk(ok, exp_t[f], {rec_b[f][0], rec_b[f][1], rec_b[f][2], rec_b[f][3]},
                {exp_b[f][0], exp_b[f][1], exp_b[f][2], exp_b[f][3]});
        end
        chk(error == err_exp, "R3 error flag", int'(error), int'(err_exp));
        chk(idx == (err_exp ? 0 : len), "R6 bytes taken", idx, err_exp ? 0 : len);
        chk(sclk_bad == 0 && idle_edge == 0, "R8 sclk timing", sclk_bad + idle_edge, 0);
        chk(min_gap >= 2 * DIV, "R9 cs gap", min_gap, 2 * DIV);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11 reset spi pins",
            {spi_cs_n, spi_sclk}, 2'b10);
        chk(done == 1'b0 && error == 1'b0 && byte_req == 1'b0, "R11 reset outputs",
            {done, error, byte_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int o = 0; o < 2; o++) begin
            for (int li = 0; li < 4; li++) begin
                for (int ti = 0; ti < 4; ti++) begin
                    int ln;
                    logic [7:0] tv;
                    ln = (li == 3) ? 5 : li;
                    tv = (ti == 0) ? 8'h5A : (ti == 1) ? 8'h00 : (ti == 2) ? 8'hFF : 8'h81;
                    run(o[0], ln, tv, (li == 3 && ti != 1));
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule